// File: doc/BRIEF.md
# Management Register Field Cell

This cell holds one field of a management register file and gives it one of several access behaviours, chosen by a parameter when it is instantiated. The register file around it decodes the address and produces a write strobe with write data and a read strobe. This cell decides how those strobes, and a hardware condition input, change the stored value. The current value goes to the controlled logic on `field_o`. The value a register read would return appears combinationally on `rd_data_o`.

The behaviours available are:

- plain read/write
- read-only status
- write-only control
- clear by writing ones
- clear by any write
- clear on read
- latch a high condition
- latch a low condition
- self-clearing command bits
- reserved

The two latching modes hold a seen condition until a read. After that read, the field tracks the live condition rather than clearing at once. A separate flag exempts the field from the synchronous software reset. The asynchronous hardware reset always initialises it.

Top module: `mgmt_field_cell`

## Requirements
- R1: In read/write mode a write strobe loads the write data on the next clock. The field then holds it, and the read value equals the field. After hardware reset the field equals the RST_VAL parameter.
- R2: In read-only mode the field equals the condition input sampled at the previous clock edge. Writes have no effect.
- R3: In write-only mode a write loads the field, and the read value is always zero.
- R4: In write-ones-to-clear mode, each bit written as 1 clears and each bit written as 0 is unchanged. A condition bit at 1 sets its field bit.
- R5: In write-anything-to-clear mode any write clears the whole field, whatever the data. A condition bit at 1 sets its field bit.
- R6: In clear-on-read mode the read value in the read cycle is the held value, and the field is zero from the next clock. Writes have no effect. A condition bit at 1 sets its field bit.
- R7: In latch-high mode a bit goes to 1 when its condition is 1. It stays 1 until a read, even if the condition goes away. A read with the condition absent clears it on the next clock.
- R8: In latch-high mode, a bit that was 1 when read stays 1 while its condition stays 1. It then drops on the first clock at which the condition is 0, with no further read.
- R9: In latch-low mode a bit reads 1 after reset and while its condition is 1. A 0 on the condition latches the bit at 0 until a read. After the read the bit follows the condition.
- R10: In self-clearing mode, writing 1 to a bit sets it and writing 0 has no effect. Without the done option a set bit clears one clock later. With the done option it holds until its done_i bit is 1 and then clears on that clock.
- R11: When a condition bit is 1 in the same cycle as a clearing write or clearing read, the field bit is 1 after that clock.
- R12: A software reset returns the field to its hardware reset value on the next clock, unless SW_RST_KEEP is set, in which case the field is unchanged. Hardware reset initialises the field in both cases.
- R13: In reserved mode both the field and the read value are zero whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| sw_rst_i | input | 1 | Synchronous software reset |
| hw_i | input | FW | Hardware condition or event, per bit |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | FW | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| done_i | input | FW | Per-bit completion for self-clearing bits |
| rd_data_o | output | FW | Value returned to a register read |
| field_o | output | FW | Current field value for the controlled logic |

## Verification
Every stored result is due one clock after the stimulus. That covers loads, clears, latches, software reset and self-clearing, because the field is a single register stage. The read value is combinational from that register and is valid in the same cycle as the read strobe. The bench therefore changes inputs just after a rising edge. It checks `rd_data_o` in that cycle for the value returned by a read, and checks stored results just after the following rising edge. The hold checks for latch and self-clear behaviour span several such edges, and each edge is sampled in turn.

// File: rtl/mgmt_fld_pkg.sv
package mgmt_fld_pkg;
  typedef enum logic [3:0] {
    FLD_RW   = 4'd0,
    FLD_RO   = 4'd1,
    FLD_WO   = 4'd2,
    FLD_W1C  = 4'd3,
    FLD_WAC  = 4'd4,
    FLD_RC   = 4'd5,
    FLD_LH   = 4'd6,
    FLD_LL   = 4'd7,
    FLD_SC   = 4'd8,
    FLD_RSVD = 4'd9
  } fld_mode_e;

  function automatic bit is_latch(fld_mode_e m);
    return (m == FLD_LH) || (m == FLD_LL);
  endfunction
endpackage

// File: rtl/fld_next.sv
module fld_next
  import mgmt_fld_pkg::*;
#(
  parameter int unsigned FW      = 8,
  parameter fld_mode_e   MODE    = FLD_RW,
  parameter bit          SC_DONE = 1'b0
) (
  input  logic [FW-1:0] q_i,
  input  logic [FW-1:0] ack_i,
  input  logic [FW-1:0] cond_i,
  input  logic          wr_en_i,
  input  logic [FW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [FW-1:0] done_i,
  output logic [FW-1:0] q_nxt_o,
  output logic [FW-1:0] ack_nxt_o
);
  logic [FW-1:0] wmask, rmask;
  assign wmask = wr_en_i ? wr_data_i : '0;
  assign rmask = {FW{rd_en_i}};

  generate
    if (MODE == FLD_RW || MODE == FLD_WO) begin : g_rw
      assign q_nxt_o   = wr_en_i ? wr_data_i : q_i;
      assign ack_nxt_o = '0;
    end else if (MODE == FLD_RO) begin : g_ro
      assign q_nxt_o   = cond_i;
      assign ack_nxt_o = '0;
    end else if (MODE == FLD_W1C) begin : g_w1c
      // event wins over clear
      assign q_nxt_o   = (q_i & ~wmask) | cond_i;
      assign ack_nxt_o = '0;
    end else if (MODE == FLD_WAC) begin : g_wac
      assign q_nxt_o   = (wr_en_i ? '0 : q_i) | cond_i;
      assign ack_nxt_o = '0;
    end else if (MODE == FLD_RC) begin : g_rc
      assign q_nxt_o   = (q_i & ~rmask) | cond_i;
      assign ack_nxt_o = '0;
    end else if (is_latch(MODE)) begin : g_latch
      // ack: bit was high when read, so it now tracks the condition
      assign q_nxt_o   = cond_i | (q_i & ~(ack_i | rmask));
      assign ack_nxt_o = (ack_i | (rmask & q_i)) & q_nxt_o;
    end else if (MODE == FLD_SC) begin : g_sc
      if (SC_DONE) begin : g_done
        assign q_nxt_o = (q_i & ~done_i) | wmask;
      end else begin : g_pulse
        assign q_nxt_o = wmask;
      end
      assign ack_nxt_o = '0;
    end else begin : g_rsvd
      assign q_nxt_o   = '0;
      assign ack_nxt_o = '0;
    end
  endgenerate
endmodule

// File: rtl/fld_store.sv
module fld_store #(
  parameter int unsigned   FW      = 8,
  parameter logic [FW-1:0] INIT    = '0,
  parameter bit            KEEP    = 1'b0,
  parameter bit            HAS_ACK = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_rst_i,
  input  logic [FW-1:0] q_nxt_i,
  input  logic [FW-1:0] ack_nxt_i,
  output logic [FW-1:0] q_o,
  output logic [FW-1:0] ack_o
);
  logic sw_clr;
  assign sw_clr = sw_rst_i && !KEEP;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= INIT;
    else if (sw_clr) q_o <= INIT;
    else             q_o <= q_nxt_i;
  end

  generate
    if (HAS_ACK) begin : g_ack
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     ack_o <= '0;
        else if (sw_clr) ack_o <= '0;
        else             ack_o <= ack_nxt_i;
      end
    end else begin : g_noack
      assign ack_o = '0;
    end
  endgenerate
endmodule

// File: rtl/fld_view.sv
module fld_view
  import mgmt_fld_pkg::*;
#(
  parameter int unsigned FW   = 8,
  parameter fld_mode_e   MODE = FLD_RW
) (
  input  logic [FW-1:0] q_i,
  output logic [FW-1:0] field_o,
  output logic [FW-1:0] rd_data_o
);
  localparam bit INV  = (MODE == FLD_LL);
  localparam bit HIDE = (MODE == FLD_WO) || (MODE == FLD_RSVD);

  assign field_o   = INV ? ~q_i : q_i;
  assign rd_data_o = HIDE ? '0 : field_o;
endmodule

// File: rtl/mgmt_field_cell.sv
module mgmt_field_cell
  import mgmt_fld_pkg::*;
#(
  parameter int unsigned   FW          = 8,
  parameter fld_mode_e     MODE        = FLD_RW,
  parameter logic [FW-1:0] RST_VAL     = '0,
  parameter bit            SW_RST_KEEP = 1'b0,
  parameter bit            SC_USE_DONE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_rst_i,
  input  logic [FW-1:0] hw_i,
  input  logic          wr_en_i,
  input  logic [FW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [FW-1:0] done_i,
  output logic [FW-1:0] rd_data_o,
  output logic [FW-1:0] field_o
);
  localparam bit            INV  = (MODE == FLD_LL);
  localparam logic [FW-1:0] INIT = (MODE == FLD_RW || MODE == FLD_WO) ? RST_VAL : '0;

  logic [FW-1:0] q, ack, q_nxt, ack_nxt, cond;

  assign cond = INV ? ~hw_i : hw_i;

  fld_next #(.FW(FW), .MODE(MODE), .SC_DONE(SC_USE_DONE)) u_next (
    .q_i       (q),
    .ack_i     (ack),
    .cond_i    (cond),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .done_i    (done_i),
    .q_nxt_o   (q_nxt),
    .ack_nxt_o (ack_nxt)
  );

  fld_store #(.FW(FW), .INIT(INIT), .KEEP(SW_RST_KEEP), .HAS_ACK(is_latch(MODE))) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sw_rst_i  (sw_rst_i),
    .q_nxt_i   (q_nxt),
    .ack_nxt_i (ack_nxt),
    .q_o       (q),
    .ack_o     (ack)
  );

  fld_view #(.FW(FW), .MODE(MODE)) u_view (
    .q_i       (q),
    .field_o   (field_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/mgmt_field_cell_chk.sv
module mgmt_field_cell_chk
  import mgmt_fld_pkg::*;
#(
  parameter int unsigned FW      = 8,
  parameter fld_mode_e   MODE    = FLD_RW,
  parameter bit          KEEP    = 1'b0,
  parameter bit          SC_DONE = 1'b0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sw_rst_i,
  input logic [FW-1:0] hw_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic [FW-1:0] rd_data_o,
  input logic [FW-1:0] field_o
);
  localparam bit M_RO   = (MODE == FLD_RO);
  localparam bit M_WO   = (MODE == FLD_WO);
  localparam bit M_WAC  = (MODE == FLD_WAC);
  localparam bit M_RC   = (MODE == FLD_RC);
  localparam bit M_SCP  = (MODE == FLD_SC) && !SC_DONE;
  localparam bit M_RSVD = (MODE == FLD_RSVD);
  localparam bit M_EVT  = (MODE == FLD_W1C) || (MODE == FLD_WAC) ||
                          (MODE == FLD_RC)  || (MODE == FLD_LH);

  // R2
  ro_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (M_RO && !sw_rst_i) |=> field_o == $past(hw_i));

  // R3
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    M_WO |-> rd_data_o == '0);

  // R5
  wac_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (M_WAC && wr_en_i && hw_i == '0) |=> field_o == '0);

  // R6
  rc_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (M_RC && wr_en_i && !rd_en_i && hw_i == '0 && !sw_rst_i) |=> $stable(field_o));

  // R10
  sc_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (M_SCP && !wr_en_i) |=> field_o == '0);

  // R11
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (M_EVT && !sw_rst_i && hw_i != '0) |=> (field_o & $past(hw_i)) == $past(hw_i));

  // R13
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    M_RSVD |-> (field_o == '0 && rd_data_o == '0));

  // R12
  keep_sw_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (KEEP && sw_rst_i && MODE == FLD_RW && !wr_en_i) |=> $stable(field_o));
endmodule

bind mgmt_field_cell mgmt_field_cell_chk #(
  .FW(FW), .MODE(MODE), .KEEP(SW_RST_KEEP), .SC_DONE(SC_USE_DONE)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sw_rst_i  (sw_rst_i),
  .hw_i      (hw_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .field_o   (field_o)
);

// File: tb/sim_mgmt_field_cell.sv
module sim_mgmt_field_cell;
  import mgmt_fld_pkg::*;

  localparam int unsigned FW = 4;
  localparam int NI = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_rst = 1'b0;
  logic [FW-1:0] hw = '0;
  logic          wr = 1'b0;
  logic [FW-1:0] wd = '0;
  logic          rd = 1'b0;
  logic [FW-1:0] done = '0;

  logic [FW-1:0] rdv [NI];
  logic [FW-1:0] fld [NI];

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mgmt_field_cell #(.FW(FW), .MODE(FLD_LH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[0]), .field_o(fld[0]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_LL)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[1]), .field_o(fld[1]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_RW), .RST_VAL(4'hA), .SW_RST_KEEP(1'b1)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[2]), .field_o(fld[2]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_RO)) u3 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[3]), .field_o(fld[3]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_WO)) u4 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[4]), .field_o(fld[4]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_W1C)) u5 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[5]), .field_o(fld[5]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_WAC)) u6 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[6]), .field_o(fld[6]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_RC)) u7 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[7]), .field_o(fld[7]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_SC)) u8 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[8]), .field_o(fld[8]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_SC), .SC_USE_DONE(1'b1)) u9 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[9]), .field_o(fld[9]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_RSVD)) u10 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[10]), .field_o(fld[10]));
  mgmt_field_cell #(.FW(FW), .MODE(FLD_RW), .RST_VAL(4'h5)) u11 (
    .clk_i(clk), .rst_ni(rst_n), .sw_rst_i(sw_rst), .hw_i(hw), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .done_i(done), .rd_data_o(rdv[11]), .field_o(fld[11]));

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // inputs change 1 ns after a rising edge; results sampled there too
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    wr = 1'b0; rd = 1'b0; sw_rst = 1'b0; done = '0;
  endtask

  task automatic clear_all(input logic [FW-1:0] hv);
    hw = hv; sw_rst = 1'b1; tick(); idle();
  endtask

  task automatic t_reset();
    chk("R12 hw reset keep", fld[2], 4'hA);
    chk("R1 reset value", fld[11], 4'h5);
    chk("R9 ll reset", fld[1], 4'hF);
    chk("R7 lh reset", fld[0], 4'h0);
    chk("R13 rsvd reset", rdv[10], 4'h0);
  endtask

  task automatic t_rw();
    clear_all(4'h0);
    wr = 1'b1; wd = 4'h3; tick(); idle();
    chk("R1 write", fld[11], 4'h3);
    chk("R1 read", rdv[11], 4'h3);
    tick();
    chk("R1 hold", fld[11], 4'h3);
  endtask

  task automatic t_swrst();
    wr = 1'b1; wd = 4'h6; tick(); idle();
    sw_rst = 1'b1; tick(); idle();
    chk("R12 sw reset", fld[11], 4'h5);
    chk("R12 sw keep", fld[2], 4'h6);
  endtask

  task automatic t_ro();
    clear_all(4'h0);
    hw = 4'h9; wr = 1'b1; wd = 4'h0; tick();
    chk("R2 follow", fld[3], 4'h9);
    hw = 4'h2; wd = 4'hF; tick(); idle();
    chk("R2 write ignored", rdv[3], 4'h2);
    hw = 4'h0;
  endtask

  task automatic t_wo();
    clear_all(4'h0);
    wr = 1'b1; wd = 4'hC; tick(); idle();
    chk("R3 field", fld[4], 4'hC);
    chk("R3 read zero", rdv[4], 4'h0);
  endtask

  task automatic t_w1c();
    clear_all(4'h0);
    hw = 4'hB; tick(); hw = 4'h0; tick();
    chk("R4 set", fld[5], 4'hB);
    wr = 1'b1; wd = 4'h3; tick();
    chk("R4 clear ones", fld[5], 4'h8);
    wd = 4'h0; tick(); idle();
    chk("R4 zero no effect", fld[5], 4'h8);
  endtask

  task automatic t_wac();
    clear_all(4'h0);
    hw = 4'h7; tick(); hw = 4'h0;
    wr = 1'b1; wd = 4'h0; tick(); idle();
    chk("R5 any write clears", fld[6], 4'h0);
  endtask

  task automatic t_rc();
    clear_all(4'h0);
    hw = 4'h5; tick(); hw = 4'h0;
    wr = 1'b1; wd = 4'hF; tick(); idle();
    chk("R6 write ignored", fld[7], 4'h5);
    rd = 1'b1; #1;
    chk("R6 read value", rdv[7], 4'h5);
    tick(); idle();
    chk("R6 cleared", fld[7], 4'h0);
  endtask

  task automatic t_event_wins();
    clear_all(4'h0);
    hw = 4'h1; tick(); hw = 4'h0; tick();
    hw = 4'h4; wr = 1'b1; wd = 4'hF; rd = 1'b1; tick(); idle(); hw = 4'h0;
    chk("R11 w1c", fld[5], 4'h4);
    chk("R11 wac", fld[6], 4'h4);
    chk("R11 rc", fld[7], 4'h4);
  endtask

  task automatic t_lh();
    clear_all(4'h0);
    hw = 4'h1; tick();
    chk("R7 set", fld[0], 4'h1);
    hw = 4'h0; tick(); tick();
    chk("R7 held", fld[0], 4'h1);
    rd = 1'b1; tick(); idle();
    chk("R7 read clears", fld[0], 4'h0);
    hw = 4'h2; tick();
    rd = 1'b1; tick(); idle();
    chk("R8 read while present", fld[0], 4'h2);
    tick();
    chk("R8 stays present", fld[0], 4'h2);
    hw = 4'h0; tick();
    chk("R8 drops", fld[0], 4'h0);
  endtask

  task automatic t_ll();
    clear_all(4'hF);
    chk("R9 idle high", fld[1], 4'hF);
    hw = 4'hE; tick(); hw = 4'hF; tick();
    chk("R9 latched low", fld[1], 4'hE);
    rd = 1'b1; tick(); idle();
    chk("R9 read releases", fld[1], 4'hF);
    hw = 4'h0;
  endtask

  task automatic t_sc();
    clear_all(4'h0);
    wr = 1'b1; wd = 4'h6; tick(); idle();
    chk("R10 set", fld[8], 4'h6);
    chk("R10 set done", fld[9], 4'h6);
    tick();
    chk("R10 self clear", fld[8], 4'h0);
    chk("R10 waits done", fld[9], 4'h6);
    done = 4'h2; tick(); idle();
    chk("R10 done clears", fld[9], 4'h4);
    wr = 1'b1; wd = 4'h0; tick(); idle();
    chk("R10 zero no effect", fld[9], 4'h4);
    done = 4'h4; tick(); idle();
    chk("R10 done last", fld[9], 4'h0);
  endtask

  task automatic t_rsvd();
    clear_all(4'h0);
    hw = 4'hF; wr = 1'b1; wd = 4'hF; tick(); idle(); hw = 4'h0;
    chk("R13 field", fld[10], 4'h0);
    chk("R13 read", rdv[10], 4'h0);
  endtask

  task automatic t_hwrst();
    wr = 1'b1; wd = 4'h3; tick(); idle();
    rst_n = 1'b0; #1;
    chk("R12 hw reset keep", fld[2], 4'hA);
    chk("R12 hw reset rw", fld[11], 4'h5);
    tick(); rst_n = 1'b1; tick();
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_rw();
    t_swrst();
    t_ro();
    t_wo();
    t_w1c();
    t_wac();
    t_rc();
    t_event_wins();
    t_lh();
    t_ll();
    t_sc();
    t_rsvd();
    t_hwrst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule